// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Engine

This block watches a demodulated infrared line that rests high and turns its activity into timed symbols. A symbol is one low phase followed by one high phase. The block measures both phases in 10 microsecond units and packs them into a 32-bit word. Each finished word goes into a small FIFO, and software drains the FIFO through a plain register read/write port. A symbol ends at the falling edge that starts the next one. When the line stays high for the configured maximum width, the stream is treated as over: the last symbol is stored with its high phase equal to that maximum, and a timeout is flagged.

Software sets the block up in a fixed order. It writes the enable register, waits while busy reads 1, and writes the configuration. A write of any value to the start register then begins capture. Three interrupt sources are provided: symbols received (FIFO count at a programmed level), end-of-stream timeout, and overflow. Each has a raw status bit, a mask bit and a write-one-to-clear bit. On overflow the stored words are kept. New symbols are dropped until software clears the overflow flag.

The line first passes through a two-flop synchronizer and a three-sample agreement filter. Durations are timed from the filtered edges. Each duration counter stops at 0xFFFF and does not wrap.

Top module: `ir_symbol_capture`

## Requirements
- R1: After reset, count (address 3), busy (address 2) and status (address 6) all read 0, and `irq` is low.
- R2: Writing 1 to address 0 makes busy read 1 for SETUP_CYC cycles. A write to start (address 8) while busy reads 1, or while the block is disabled, is ignored.
- R3: Line activity before capture has been started produces no words, and count stays 0.
- R4: With prescaler field p in config bits [6:0], one unit is 10·(p+1) clock cycles. A word holds the low duration in bits [15:0] and the high duration in bits [31:16]. A phase that lasts 10·n·(p+1)+k cycles with 0<k≤10·(p+1) reads n units. Capture runs only when config bit 7 is 1 and bits [15:14] are 0.
- R5: When the high phase reaches the maximum width in config bits [31:16], a word is stored with its high half equal to that maximum, and timeout status bit 9 is set.
- R6: Address 3 returns the number of stored words. Each read of address 4 returns the oldest word and removes it. Words come out in arrival order.
- R7: Received status bit 8 is set when a stored word brings the count to the level field (config bits [13:8]) plus one. A smaller count leaves it clear.
- R8: The FIFO holds 16 words. A symbol that arrives while the FIFO is full sets overflow bit 10 and is dropped. Stored words are kept, and every later symbol is dropped until bit 10 is cleared, even if words have been read out.
- R9: Writing 1 to bit 16, 17 or 18 of address 7 clears status bit 8, 9 or 10 respectively. Bits written 0 leave their flags unchanged.
- R10: Mask register (address 5) bits [10:8] block the matching sources. Status bits [26:24] read raw bits [10:8] with masked sources forced to 0, and `irq` is the OR of bits [26:24].
- R11: A low pulse of two cycles or less on `ir_in` is filtered out and produces neither a word nor a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, idles high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO on data address) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Interrupt, OR of unmasked status flags |

## Verification
A symbol-tracking state that does not return to idle after a timeout shows up on the next stream. The next word then carries a wrong low half, or an extra word appears, as soon as that stream is drained. A wrong FIFO pointer or count shows up on the very next count read or data pop as a wrong word or a wrong order. A wrong overflow hold shows up as a count that changes after a dropped symbol, within one stream. A timing-base fault shifts every duration by one unit or more, and the first data pop after the first stream shows it.

// File: rtl/ir_cap_pkg.sv
// ir_cap_pkg: register addresses, capture states and status bit positions
// shared by the capture engine and its bench.
package ir_cap_pkg;
    typedef enum logic [3:0] {
        A_ENABLE = 4'd0,
        A_CONFIG = 4'd1,
        A_BUSY   = 4'd2,
        A_COUNT  = 4'd3,
        A_DATA   = 4'd4,
        A_MASK   = 4'd5,
        A_STATUS = 4'd6,
        A_CLEAR  = 4'd7,
        A_START  = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_LOW  = 2'd1,
        CAP_HIGH = 2'd2
    } cap_state_e;

    localparam int STS_LSB = 8;   // raw flags at [10:8]
    localparam int CLR_LSB = 16;  // clear strobes at [18:16]
    localparam int MSK_LSB = 24;  // masked flags at [26:24]
endpackage

// File: rtl/ir_in_cond.sv
// ir_in_cond: brings the raw line into the clock domain and filters it.
// Assumes ir_raw is asynchronous and idles high. The filtered level only
// changes once FILT_LEN synchronized samples agree. Single-cycle fall and
// rise pulses are produced from the filtered level.
module ir_in_cond #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_raw,
    output logic fall,
    output logic rise
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                level_q;
    logic                level_d_q;

    // Synchronize, keep the sample history, and update the agreed level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q    <= '1;
            hist_q    <= '1;
            level_q   <= 1'b1;
            level_d_q <= 1'b1;
        end else begin
            sync_q    <= {sync_q[0], ir_raw};
            hist_q    <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            level_d_q <= level_q;
            if (&hist_q)
                level_q <= 1'b1;
            else if (~|hist_q)
                level_q <= 1'b0;
        end
    end

    assign fall = level_d_q & ~level_q;
    assign rise = ~level_d_q & level_q;

    // R11: a change of the filtered level needs a full agreeing history.
    a_r11_filter_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != level_d_q) |-> ($past(hist_q) == {FILT_LEN{level_q}}));
endmodule

// File: rtl/ir_unit_tick.sv
// ir_unit_tick: timing base. The prescaler gives a tick every presc+1
// cycles, and a decade divider turns DEC ticks into one unit pulse.
// A restart (any filtered edge) realigns both, so that a phase is timed
// from its own edge.
module ir_unit_tick #(
    parameter int PRE_W = 7,
    parameter int DEC   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] presc,
    output logic             unit
);
    localparam int DEC_W = $clog2(DEC);

    logic [PRE_W-1:0] pre_q;
    logic [DEC_W-1:0] dec_q;
    logic             us_tick;

    assign us_tick = (pre_q == presc);

    // Advance the prescaler and the decade divider; realign on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
            dec_q <= '0;
        end else if (us_tick) begin
            pre_q <= '0;
            dec_q <= (dec_q == DEC_W'(DEC - 1)) ? '0 : dec_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign unit = us_tick && (dec_q == DEC_W'(DEC - 1)) && !restart;
endmodule

// File: rtl/ir_sym_fifo.sv
// ir_sym_fifo: symbol word store with a first-in first-out read order.
// Assumes that the caller never pushes when full and never pops when empty.
// flush empties it in one cycle.
module ir_sym_fifo #(
    parameter  int W     = 32,
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;

    // Store the pushed word.
    always_ff @(posedge clk) begin
        if (push)
            mem_q[wr_q] <= wdata;
    end

    // Move the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (push)
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end

    assign head  = mem_q[rd_q];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // R8: the store never holds more than DEPTH words.
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R8: the caller's push gate keeps a full store untouched.
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R6: a pop only happens when a word is present.
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/ir_symbol_capture.sv
// ir_symbol_capture: raw infrared symbol capture with a register port.
// Assumes ir_in is a demodulated line that idles high. A symbol is one low
// phase followed by one high phase, timed in units from ir_unit_tick. Words
// go to ir_sym_fifo. Overflow drops new words and keeps stored ones.
// reg_rdata is combinational. A read of the data address pops at the edge.
module ir_symbol_capture
    import ir_cap_pkg::*;
#(
    parameter int          DEPTH     = 16,
    parameter int          SETUP_CYC = 8,
    parameter logic [31:0] CFG_RESET = 32'h3E80_0080
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BSY_W = $clog2(SETUP_CYC + 1);

    logic             en_q, run_q;
    logic [BSY_W-1:0] busy_q;
    logic [31:0]      cfg_q;
    logic [2:0]       mask_q, sts_q, sts_set, sts_clr, masked;
    cap_state_e       state_q;
    logic [15:0]      low_q, high_q, low_nx, high_nx;
    logic             fall, rise, unit, active, busy;
    logic             push_req, tmo_evt, fifo_push, fifo_pop;
    logic             fifo_full, fifo_empty, wr_enable;
    logic [31:0]      word, fifo_head;
    logic [CNT_W-1:0] fifo_count;

    assign wr_enable = reg_wr && (reg_addr == A_ENABLE);
    assign busy      = (busy_q != '0);
    assign active    = run_q && cfg_q[7] && (cfg_q[15:14] == 2'b00);

    ir_in_cond #(.FILT_LEN(3)) cond_i (
        .clk(clk), .rst_n(rst_n), .ir_raw(ir_in), .fall(fall), .rise(rise));

    ir_unit_tick #(.PRE_W(7), .DEC(10)) tick_i (
        .clk(clk), .rst_n(rst_n), .restart(fall | rise),
        .presc(cfg_q[6:0]), .unit(unit));

    // Enable, setup-busy countdown and the start gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            run_q  <= 1'b0;
            busy_q <= '0;
        end else if (wr_enable) begin
            en_q   <= reg_wdata[0];
            run_q  <= 1'b0;
            busy_q <= reg_wdata[0] ? BSY_W'(SETUP_CYC) : '0;
        end else begin
            if (busy)
                busy_q <= busy_q - 1'b1;
            if (reg_wr && reg_addr == A_START && en_q && !busy)
                run_q <= 1'b1;
        end
    end

    // Configuration and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RESET;
            mask_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CONFIG)
                cfg_q <= reg_wdata;
            if (reg_addr == A_MASK)
                mask_q <= reg_wdata[STS_LSB+2:STS_LSB];
        end
    end

    // Saturating next values and symbol completion events.
    always_comb begin
        low_nx   = (low_q == 16'hFFFF) ? low_q : low_q + 16'd1;
        high_nx  = (high_q == 16'hFFFF) ? high_q : high_q + 16'd1;
        tmo_evt  = active && (state_q == CAP_HIGH) && unit && !fall &&
                   (high_nx >= cfg_q[31:16]);
        push_req = (active && (state_q == CAP_HIGH) && fall) || tmo_evt;
        word     = tmo_evt ? {high_nx, low_q} : {high_q, low_q};
    end

    // Symbol phase tracking: idle, low, high.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state_q <= CAP_IDLE;
            low_q   <= '0;
            high_q  <= '0;
        end else begin
            unique case (state_q)
                CAP_IDLE: if (fall) begin
                    state_q <= CAP_LOW;
                    low_q   <= '0;
                end
                CAP_LOW: if (rise) begin
                    state_q <= CAP_HIGH;
                    high_q  <= '0;
                end else if (unit) begin
                    low_q <= low_nx;
                end
                CAP_HIGH: if (fall) begin
                    state_q <= CAP_LOW;
                    low_q   <= '0;
                end else if (tmo_evt) begin
                    state_q <= CAP_IDLE;
                end else if (unit) begin
                    high_q <= high_nx;
                end
                default: state_q <= CAP_IDLE;
            endcase
        end
    end

    assign fifo_push = push_req && !fifo_full && !sts_q[2];
    assign fifo_pop  = reg_rd && (reg_addr == A_DATA) && !fifo_empty;

    ir_sym_fifo #(.W(32), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(wr_enable), .push(fifo_push),
        .wdata(word), .pop(fifo_pop), .head(fifo_head), .count(fifo_count),
        .full(fifo_full), .empty(fifo_empty));

    // Status set and write-one-to-clear strobes.
    always_comb begin
        sts_set[0] = fifo_push && (int'(fifo_count) >= int'(cfg_q[13:8]));
        sts_set[1] = tmo_evt;
        sts_set[2] = push_req && !fifo_push;
        sts_clr    = (reg_wr && reg_addr == A_CLEAR) ?
                     reg_wdata[CLR_LSB+2:CLR_LSB] : 3'b000;
    end

    // Status flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_enable)
            sts_q <= '0;
        else
            sts_q <= (sts_q & ~sts_clr) | sts_set;
    end

    assign masked = sts_q & ~mask_q;
    assign irq    = |masked;

    // Read data selection.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_ENABLE: reg_rdata[0] = en_q;
            A_CONFIG: reg_rdata = cfg_q;
            A_BUSY:   reg_rdata[0] = busy;
            A_COUNT:  reg_rdata[CNT_W-1:0] = fifo_count;
            A_DATA:   reg_rdata = fifo_empty ? '0 : fifo_head;
            A_MASK:   reg_rdata[STS_LSB+2:STS_LSB] = mask_q;
            A_STATUS: begin
                reg_rdata[STS_LSB+2:STS_LSB] = sts_q;
                reg_rdata[MSK_LSB+2:MSK_LSB] = masked;
            end
            default:  reg_rdata = '0;
        endcase
    end

    // R2: capture only starts from an enabled, settled block.
    a_r2_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(en_q && !busy));
    // R5: a timeout flag only comes from a high phase.
    a_r5_tmo_from_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[1]) |-> $past(state_q) == CAP_HIGH);
    // R8: while overflow is flagged, the count does not rise.
    a_r8_hold_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[2] && !fifo_pop && !wr_enable) |=> fifo_count == $past(fifo_count));
    // R7: the received flag rises only once the level has been reached.
    a_r7_rcv_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[0]) |-> int'(fifo_count) >= int'(cfg_q[13:8]));
endmodule

// File: tb/ir_symbol_capture_tb_top.sv
// Directed bench for ir_symbol_capture: one task per scenario. The
// prescaler is 0, so one unit is 10 cycles, and the maximum width is 20.
module ir_symbol_capture_tb_top;
    import ir_cap_pkg::*;

    localparam int SETUP = 8;
    localparam int MAXW  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    ir_symbol_capture #(.DEPTH(16), .SETUP_CYC(SETUP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input reg_addr_e a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input reg_addr_e a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input reg_addr_e a,
                          input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic hold(input logic v, input int cyc);
        ir_in = v;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic send_sym(input int lo, input int hi);
        hold(1'b0, 10*lo + 5);
        hold(1'b1, 10*hi + 5);
    endtask

    task automatic end_stream(input int lo);
        hold(1'b0, 10*lo + 5);
        hold(1'b1, 10*MAXW + 60);
    endtask

    function automatic logic [31:0] w(input int lo, input int hi);
        return {16'(hi), 16'(lo)};
    endfunction

    task automatic t_reset();
        rd_chk("R1 count", A_COUNT, 0);
        rd_chk("R1 busy", A_BUSY, 0);
        rd_chk("R1 status", A_STATUS, 0);
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_setup();
        wr(A_ENABLE, 1);
        rd_chk("R2 busy after enable", A_BUSY, 1);
        wr(A_START, 1);                       // R2: ignored while busy
        repeat (SETUP + 2) @(negedge clk);
        rd_chk("R2 busy settles", A_BUSY, 0);
        wr(A_CONFIG, {16'(MAXW), 2'b00, 6'd2, 1'b1, 7'd0});
        send_sym(3, 2);
        end_stream(1);
        rd_chk("R2 R3 no words before start", A_COUNT, 0);
        rd_chk("R3 no status before start", A_STATUS, 0);
        wr(A_START, 1);
    endtask

    task automatic t_stream();
        send_sym(3, 2); send_sym(5, 4); send_sym(1, 7);
        end_stream(2);
        rd_chk("R6 count of stream", A_COUNT, 4);
        rd_chk("R7 R5 status rcv+tmo", A_STATUS, 32'h0300_0300);
        chk("R10 irq with flags", {31'd0, irq}, 1);
        rd_chk("R4 word 1", A_DATA, w(3, 2));
        rd_chk("R4 word 2", A_DATA, w(5, 4));
        rd_chk("R6 word 3", A_DATA, w(1, 7));
        rd_chk("R5 timeout word", A_DATA, w(2, MAXW));
        rd_chk("R6 drained", A_COUNT, 0);
    endtask

    task automatic t_clear();
        wr(A_CLEAR, 32'h0001_0000);
        rd_chk("R9 clear rcv only", A_STATUS, 32'h0200_0200);
        wr(A_CLEAR, 32'h0002_0000);
        rd_chk("R9 clear tmo", A_STATUS, 0);
        chk("R9 irq low", {31'd0, irq}, 0);
    endtask

    task automatic t_below_level();
        send_sym(1, 1);
        end_stream(1);
        rd_chk("R7 below level no rcv", A_STATUS, 32'h0200_0200);
        rd_chk("R7 count 2", A_COUNT, 2);
        rd_chk("R4 short word", A_DATA, w(1, 1));
        rd_chk("R5 short timeout", A_DATA, w(1, MAXW));
        wr(A_CLEAR, 32'h0007_0000);
    endtask

    task automatic t_mask();
        wr(A_MASK, 32'h0000_0200);
        end_stream(1);
        rd_chk("R10 masked tmo", A_STATUS, 32'h0000_0200);
        chk("R10 irq masked", {31'd0, irq}, 0);
        wr(A_MASK, 0);
        rd_chk("R10 unmasked tmo", A_STATUS, 32'h0200_0200);
        chk("R10 irq unmasked", {31'd0, irq}, 1);
        rd_chk("R5 lone timeout word", A_DATA, w(1, MAXW));
        wr(A_CLEAR, 32'h0007_0000);
    endtask

    task automatic t_glitch();
        hold(1'b0, 2);
        hold(1'b1, 300);
        rd_chk("R11 glitch count", A_COUNT, 0);
        rd_chk("R11 glitch status", A_STATUS, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        for (int i = 0; i < 17; i++) send_sym(1, 1);
        end_stream(1);
        rd_chk("R8 full count", A_COUNT, 16);
        rd(A_STATUS, v);
        chk("R8 ovf flag", {31'd0, v[10]}, 1);
        rd_chk("R8 first kept", A_DATA, w(1, 1));
        send_sym(1, 1);
        end_stream(1);
        rd_chk("R8 dropped while flagged", A_COUNT, 15);
        for (int i = 0; i < 14; i++) rd(A_DATA, v);
        rd_chk("R8 last kept word", A_DATA, w(1, 1));
        rd_chk("R8 empty", A_COUNT, 0);
        wr(A_CLEAR, 32'h0007_0000);
        rd_chk("R9 all cleared", A_STATUS, 0);
        send_sym(3, 2);
        end_stream(2);
        rd_chk("R8 accepts after clear", A_COUNT, 2);
        rd_chk("R8 word after clear", A_DATA, w(3, 2));
        rd_chk("R5 timeout after clear", A_DATA, w(2, MAXW));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_stream();
        t_clear();
        t_below_level();
        t_mask();
        t_glitch();
        t_overflow();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule